// File: doc/BRIEF.md
# Byte/Word ALU with Registered Status Flags

This block is the arithmetic and logic stage of a small 16-bit processor that can also work on 8-bit quantities. Each operation arrives as one beat on a valid/ready input stream. A beat carries an operation code, a byte-mode bit and two operands: a source and a destination. The block computes the result in a single combinational pass. In the same clock edge that accepts the beat, it loads the result into a one-entry output register and commits the new carry, zero, negative and overflow flags to its status register.

The output stream presents the result together with two qualifiers. The first says whether the result should be written back. The second says whether the status flags were updated. The block holds the output beat until the consumer takes it. A new beat is accepted when the output register is empty or is being drained in the same cycle.

The status register is exported as a 16-bit status word. A separate branch-condition port evaluates one of eight jump conditions against that register without any extra latency. Because flags commit at acceptance, an operation accepted in the very next cycle already uses the updated carry. This holds even if the earlier result is still waiting on the output.

Top module: `bwalu`

## Requirements
- R1: Handshake. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_result`, `out_wb` and `out_flag_we` stay stable. One output beat appears per accepted input beat, in acceptance order, one cycle after acceptance.
- R2: Add (op 0) and add-with-carry (op 1). The result is dst + src (+ C for op 1), truncated to the operation width. C is the carry out of that width. V is set when the signed sum does not fit the width. N is the result's top bit at the width, and Z is set when the result is zero. All of these ops write back.
- R3: Subtract (op 2), subtract-with-carry (op 3) and compare (op 4). Each computes dst + ~src + k, where k is 1 for ops 2 and 4 and the current C for op 3. C, V, N and Z follow the rules of R2. Compare updates the flags with `out_wb` = 0, and `out_result` still shows the difference.
- R4: Decimal add (op 5). Each nibble is treated as a decimal digit of weight 10^i, and the current C is added in. The result is the decimal sum modulo 100 in byte mode or 10000 in word mode. C is set when the decimal sum exceeds 99 (byte) or 9999 (word). V is cleared, and N and Z follow the result.
- R5: AND (op 6) and test (op 7). Both compute dst & src, set C when the result is nonzero, clear V, and set N and Z from the result. Test gives `out_wb` = 0.
- R6: Exclusive OR (op 10) computes dst ^ src and sets C when the result is nonzero. V is set exactly when both operands have their top bit (at the width) set. N and Z follow the result.
- R7: Clear-bits (op 8) gives dst & ~src, and set-bits (op 9) gives dst | src. Both write back and leave all four flags unchanged, with `out_flag_we` = 0. Op 15 is reserved: it returns dst with `out_wb` = 0 and leaves the flags unchanged.
- R8: Rotate right through carry (op 11) shifts the old C into the top bit (at the width). Arithmetic shift right (op 12) keeps the top bit. Both move the old bit 0 into C, clear V, and set N and Z from the result.
- R9: Byte swap (op 13) exchanges bits 15:8 and 7:0. Sign-extend (op 14) copies bit 7 into bits 15:8. Both always work on the full 16-bit dst, whatever the byte-mode bit says. They set N and Z from the 16-bit result and leave C and V unchanged.
- R10: With `in_byte` = 1, every operation except ops 13 and 14 uses only bits 7:0 of both operands. It returns zero in bits 15:8 and takes N, C and V from bit 7 and the 8-bit boundary.
- R11: Status word layout. C is at bit 0, Z at bit 1, N at bit 2 and V at bit 8. All other bits read 0.
- R12: `br_taken` is combinational on the current flags, selected by `br_cond`. The encodings are: 0 not-equal (Z = 0), 1 equal (Z = 1), 2 no-carry (C = 0), 3 carry (C = 1), 4 negative (N = 1), 5 greater-or-equal (N = V), 6 less (N != V), 7 always.
- R13: Flags commit on the edge that accepts a beat, so the status word changes one cycle after acceptance. The carry-in of the next accepted beat uses the committed value, regardless of output stalls.
- R14: After reset, `out_valid` is 0, `in_ready` is 1 and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation beat offered |
| in_ready | output | 1 | Operation beat can be taken |
| in_op | input | 4 | Operation code (see requirements) |
| in_byte | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| in_src | input | 16 | Source operand |
| in_dst | input | 16 | Destination operand |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_result | output | 16 | Result value |
| out_wb | output | 1 | Result is to be written back |
| out_flag_we | output | 1 | Flags were updated by this operation |
| flags_word | output | 16 | Status word (C bit 0, Z bit 1, N bit 2, V bit 8) |
| br_cond | input | 3 | Branch condition select |
| br_taken | output | 1 | Selected condition holds on current flags |

## Verification
Two functions of this block can meet in the same cycle. One is the acceptance of a new, carry-consuming operation together with its flag commit. The other is a stalled earlier result still held on the output. The bench provokes this by throttling `out_ready` at random while it issues back-to-back operations, many of which read the carry, such as add-with-carry, subtract-with-carry, decimal add and rotate.

A behavioural model tracks the flags as integers and keeps the expected beats in a queue. On every clock it compares the output beat, the status word, the branch result for a randomly chosen condition and the ready signal. A carry consumed too early or too late, or a beat lost or duplicated under back-pressure, therefore shows up as a miscompare in the cycle where it happens.

// File: rtl/bwalu_pkg.sv
`timescale 1ns/1ps
package bwalu_pkg;

  localparam int unsigned FLAG_C_BIT = 0;
  localparam int unsigned FLAG_Z_BIT = 1;
  localparam int unsigned FLAG_N_BIT = 2;
  localparam int unsigned FLAG_V_BIT = 8;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADDC   = 4'd1,
    OP_SUB    = 4'd2,
    OP_SUBC   = 4'd3,
    OP_CMP    = 4'd4,
    OP_DECADD = 4'd5,
    OP_AND    = 4'd6,
    OP_TEST   = 4'd7,
    OP_CLR    = 4'd8,
    OP_SET    = 4'd9,
    OP_XOR    = 4'd10,
    OP_RORC   = 4'd11,
    OP_ASR    = 4'd12,
    OP_SWAP   = 4'd13,
    OP_SEXT   = 4'd14,
    OP_RSV    = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    CC_NE = 3'd0,
    CC_EQ = 3'd1,
    CC_NC = 3'd2,
    CC_CS = 3'd3,
    CC_MI = 3'd4,
    CC_GE = 3'd5,
    CC_LT = 3'd6,
    CC_AL = 3'd7
  } cond_e;

  typedef enum logic [1:0] {
    SH_RORC = 2'd0,
    SH_ASR  = 2'd1,
    SH_SWAP = 2'd2,
    SH_SEXT = 2'd3
  } shift_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/bwalu_addsub.sv
`timescale 1ns/1ps
// Shared binary adder: dst + (src or ~src) + carry-in, at byte or word width.
module bwalu_addsub #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              subtract,
  input  logic              byte_mode,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int BYTE_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] a_m;
  logic [DATA_W-1:0] b_m;
  logic [DATA_W:0]   full;
  logic              msb_a;
  logic              msb_b;
  logic              msb_r;

  always_comb begin
    mask  = byte_mode ? LOW_MASK : '1;
    a_m   = a & mask;
    b_m   = (subtract ? ~b : b) & mask;
    full  = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin};
    sum   = full[DATA_W-1:0] & mask;
    cout  = byte_mode ? full[BYTE_W] : full[DATA_W];
    msb_a = byte_mode ? a_m[BYTE_W-1] : a_m[DATA_W-1];
    msb_b = byte_mode ? b_m[BYTE_W-1] : b_m[DATA_W-1];
    msb_r = byte_mode ? sum[BYTE_W-1] : sum[DATA_W-1];
    ovf   = (msb_a == msb_b) && (msb_r != msb_a);
  end

endmodule

// File: rtl/bwalu_decadd.sv
`timescale 1ns/1ps
// Ripple decimal adder: one cell per nibble, inter-digit carry of 0..3.
module bwalu_decadd #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              byte_mode,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  localparam int DIGITS = DATA_W / 4;
  localparam int HALF   = DIGITS / 2;

  logic [1:0] car [0:DIGITS];

  assign car[0] = {1'b0, cin};

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [5:0] t;
    logic [1:0] q;
    logic [3:0] k;

    assign t = {2'b00, a[4*g +: 4]} + {2'b00, b[4*g +: 4]} + {4'b0000, car[g]};

    always_comb begin
      if (t >= 6'd30) begin
        q = 2'd3;
        k = 4'd14;
      end else if (t >= 6'd20) begin
        q = 2'd2;
        k = 4'd4;
      end else if (t >= 6'd10) begin
        q = 2'd1;
        k = 4'd10;
      end else begin
        q = 2'd0;
        k = 4'd0;
      end
    end

    // low nibble of t - 10*q, taken modulo 16
    assign sum[4*g +: 4] = t[3:0] - k;
    assign car[g+1]      = q;
  end

  assign cout = byte_mode ? (car[HALF] != 2'd0) : (car[DIGITS] != 2'd0);

endmodule

// File: rtl/bwalu_shift.sv
`timescale 1ns/1ps
// Single-operand unit: rotate through carry, arithmetic shift, swap, sign extend.
module bwalu_shift import bwalu_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] d,
  input  logic              cin,
  input  logic              byte_mode,
  input  shift_e            sel,
  output logic [DATA_W-1:0] r,
  output logic              cout
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int HI_W   = DATA_W - BYTE_W;

  always_comb begin
    case (sel)
      SH_RORC: r = byte_mode ? {{HI_W{1'b0}}, cin, d[BYTE_W-1:1]}
                             : {cin, d[DATA_W-1:1]};
      SH_ASR:  r = byte_mode ? {{HI_W{1'b0}}, d[BYTE_W-1], d[BYTE_W-1:1]}
                             : {d[DATA_W-1], d[DATA_W-1:1]};
      SH_SWAP: r = {d[BYTE_W-1:0], d[DATA_W-1:BYTE_W]};
      default: r = {{HI_W{d[BYTE_W-1]}}, d[BYTE_W-1:0]};
    endcase
    cout = d[0];
  end

endmodule

// File: rtl/bwalu_cond.sv
`timescale 1ns/1ps
// Branch condition evaluator on committed flags.
module bwalu_cond import bwalu_pkg::*; (
  input  flags_t f,
  input  cond_e  sel,
  output logic   taken
);
  always_comb begin
    case (sel)
      CC_NE:   taken = !f.z;
      CC_EQ:   taken = f.z;
      CC_NC:   taken = !f.c;
      CC_CS:   taken = f.c;
      CC_MI:   taken = f.n;
      CC_GE:   taken = (f.n == f.v);
      CC_LT:   taken = (f.n != f.v);
      default: taken = 1'b1;
    endcase
  end
endmodule

// File: rtl/bwalu.sv
`timescale 1ns/1ps
module bwalu #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic              in_byte,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wb,
  output logic              out_flag_we,
  output logic [DATA_W-1:0] flags_word,
  input  logic [2:0]        br_cond,
  output logic              br_taken
);
  import bwalu_pkg::*;

  localparam int BYTE_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  alu_op_e           op;
  flags_t            flag_q;
  flags_t            flag_nx;
  logic              fire_in;
  logic              narrow;
  logic              whole_word_op;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] src_m;
  logic [DATA_W-1:0] dst_m;
  logic              src_msb;
  logic              dst_msb;

  logic              as_sub;
  logic              as_cin;
  logic [DATA_W-1:0] as_sum;
  logic              as_c;
  logic              as_v;

  logic [DATA_W-1:0] dec_sum;
  logic              dec_c;

  shift_e            sh_sel;
  logic [DATA_W-1:0] sh_in;
  logic [DATA_W-1:0] sh_r;
  logic              sh_c;

  logic [DATA_W-1:0] res;
  logic              fwe;
  logic              wb;

  // ---------------- operand preparation ----------------
  assign op            = alu_op_e'(in_op);
  assign in_ready      = !out_valid || out_ready;
  assign fire_in       = in_valid && in_ready;
  assign whole_word_op = (op == OP_SWAP) || (op == OP_SEXT);
  assign narrow        = in_byte && !whole_word_op;
  assign mask          = narrow ? LOW_MASK : '1;
  assign src_m         = in_src & mask;
  assign dst_m         = in_dst & mask;
  assign src_msb       = narrow ? src_m[BYTE_W-1] : src_m[DATA_W-1];
  assign dst_msb       = narrow ? dst_m[BYTE_W-1] : dst_m[DATA_W-1];

  // ---------------- binary adder ----------------
  assign as_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADDC) || (op == OP_SUBC)) ? flag_q.c : as_sub;

  bwalu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a         (dst_m),
    .b         (src_m),
    .subtract  (as_sub),
    .byte_mode (narrow),
    .cin       (as_cin),
    .sum       (as_sum),
    .cout      (as_c),
    .ovf       (as_v)
  );

  // ---------------- decimal adder ----------------
  bwalu_decadd #(.DATA_W(DATA_W)) u_decadd (
    .a         (dst_m),
    .b         (src_m),
    .cin       (flag_q.c),
    .byte_mode (narrow),
    .sum       (dec_sum),
    .cout      (dec_c)
  );

  // ---------------- single-operand unit ----------------
  always_comb begin
    case (op)
      OP_RORC: sh_sel = SH_RORC;
      OP_ASR:  sh_sel = SH_ASR;
      OP_SWAP: sh_sel = SH_SWAP;
      default: sh_sel = SH_SEXT;
    endcase
  end

  assign sh_in = whole_word_op ? in_dst : dst_m;

  bwalu_shift #(.DATA_W(DATA_W)) u_shift (
    .d         (sh_in),
    .cin       (flag_q.c),
    .byte_mode (narrow),
    .sel       (sh_sel),
    .r         (sh_r),
    .cout      (sh_c)
  );

  // ---------------- result and flag selection ----------------
  always_comb begin
    res     = dst_m;
    flag_nx = flag_q;
    fwe     = 1'b1;
    wb      = 1'b1;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        res       = as_sum;
        flag_nx.c = as_c;
        flag_nx.v = as_v;
        wb        = (op != OP_CMP);
      end
      OP_DECADD: begin
        res       = dec_sum & mask;
        flag_nx.c = dec_c;
        flag_nx.v = 1'b0;
      end
      OP_AND, OP_TEST: begin
        res       = dst_m & src_m;
        flag_nx.c = (res != '0);
        flag_nx.v = 1'b0;
        wb        = (op == OP_AND);
      end
      OP_XOR: begin
        res       = dst_m ^ src_m;
        flag_nx.c = (res != '0);
        flag_nx.v = dst_msb && src_msb;
      end
      OP_CLR: begin
        res = dst_m & ~src_m;
        fwe = 1'b0;
      end
      OP_SET: begin
        res = dst_m | src_m;
        fwe = 1'b0;
      end
      OP_RORC, OP_ASR: begin
        res       = sh_r;
        flag_nx.c = sh_c;
        flag_nx.v = 1'b0;
      end
      OP_SWAP, OP_SEXT: begin
        res = sh_r;
      end
      default: begin
        res = dst_m;
        fwe = 1'b0;
        wb  = 1'b0;
      end
    endcase
    if (fwe) begin
      flag_nx.n = narrow ? res[BYTE_W-1] : res[DATA_W-1];
      flag_nx.z = (res == '0);
    end
  end

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q      <= '0;
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_wb      <= 1'b0;
      out_flag_we <= 1'b0;
    end else if (fire_in) begin
      flag_q      <= flag_nx;
      out_valid   <= 1'b1;
      out_result  <= res;
      out_wb      <= wb;
      out_flag_we <= fwe;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  always_comb begin
    flags_word             = '0;
    flags_word[FLAG_C_BIT] = flag_q.c;
    flags_word[FLAG_Z_BIT] = flag_q.z;
    flags_word[FLAG_N_BIT] = flag_q.n;
    flags_word[FLAG_V_BIT] = flag_q.v;
  end

  bwalu_cond u_cond (
    .f     (flag_q),
    .sel   (cond_e'(br_cond)),
    .taken (br_taken)
  );

  // ---------------- assertions ----------------
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_wb) && $stable(out_flag_we)));

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP})) |=>
      (flags_word[FLAG_Z_BIT] == (out_result == '0)));

  p_logic_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && ((op == OP_AND) || (op == OP_TEST))) |=>
      (!flags_word[FLAG_V_BIT] && (flags_word[FLAG_C_BIT] == (out_result != '0))));

  p_flags_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && ((op == OP_CLR) || (op == OP_SET) || (op == OP_RSV))) |=>
      ($stable(flags_word) && !out_flag_we));

  p_byte_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && in_byte && !whole_word_op) |=>
      (out_result[DATA_W-1:BYTE_W] == '0));

  p_one_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire_in |=> out_valid);

endmodule

// File: tb/bwalu_bench.sv
`timescale 1ns/1ps
module bwalu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_byte = 1'b0;
  logic [15:0] in_src = '0;
  logic [15:0] in_dst = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_result;
  logic        out_wb;
  logic        out_flag_we;
  logic [15:0] flags_word;
  logic [2:0]  br_cond = '0;
  logic        br_taken;

  always #4 clk = ~clk;

  bwalu u_bwalu (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_byte(in_byte),
    .in_src(in_src), .in_dst(in_dst),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wb(out_wb), .out_flag_we(out_flag_we),
    .flags_word(flags_word), .br_cond(br_cond), .br_taken(br_taken)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  bit run = 0;
  bit drain = 0;
  int mc = 0, mz = 0, mn = 0, mv = 0;

  typedef struct { int r; bit wb; bit fwe; int op; bit byt; } exp_t;
  exp_t expq[$];

  function automatic int dec_val(int v);
    return (v & 15) + ((v >> 4) & 15) * 10 + ((v >> 8) & 15) * 100 + ((v >> 12) & 15) * 1000;
  endfunction

  function automatic int to_dec(int x);
    return (x % 10) | (((x / 10) % 10) << 4) | (((x / 100) % 10) << 8) | (((x / 1000) % 10) << 12);
  endfunction

  function automatic string tag_of(int op, bit byt);
    string t;
    case (op)
      0, 1:      t = "R2";
      2, 3, 4:   t = "R3";
      5:         t = "R4";
      6, 7:      t = "R5";
      10:        t = "R6";
      11, 12:    t = "R8";
      13, 14:    t = "R9";
      default:   t = "R7";
    endcase
    if (byt && op != 13 && op != 14) t = {t, "/R10"};
    return t;
  endfunction

  function automatic bit br_model(int c);
    case (c)
      0: return mz == 0;
      1: return mz == 1;
      2: return mc == 0;
      3: return mc == 1;
      4: return mn == 1;
      5: return mn == mv;
      6: return mn != mv;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Behavioural model of one operation; updates model flags and queues the beat.
  task automatic model_exec(int op, bit byt, int s, int d);
    int w, mask, sb, dd, ss, r, u, sd, sv, k, sum, lim, nsb;
    bit wb, fwe, nz;
    exp_t e;
    w = (byt && op != 13 && op != 14) ? 8 : 16;
    mask = (1 << w) - 1;
    sb = 1 << (w - 1);
    dd = d & mask;
    ss = s & mask;
    wb = 1; fwe = 1; nz = 1; r = dd;
    case (op)
      0, 1: begin
        k = (op == 1) ? mc : 0;
        u = dd + ss + k;
        r = u & mask;
        mc = (u > mask);
        sd = (dd & sb) ? dd - (sb << 1) : dd;
        sv = (ss & sb) ? ss - (sb << 1) : ss;
        sum = sd + sv + k;
        mv = (sum > sb - 1) || (sum < -sb);
      end
      2, 3, 4: begin
        k = (op == 3) ? mc : 1;
        u = dd + ((~ss) & mask) + k;
        r = u & mask;
        mc = (u > mask);
        sd = (dd & sb) ? dd - (sb << 1) : dd;
        sv = (ss & sb) ? ss - (sb << 1) : ss;
        sum = sd - sv - 1 + k;
        mv = (sum > sb - 1) || (sum < -sb);
        wb = (op != 4);
      end
      5: begin
        sum = dec_val(dd) + dec_val(ss) + mc;
        lim = (w == 8) ? 99 : 9999;
        mc = (sum > lim);
        r = to_dec(sum) & mask;
        mv = 0;
      end
      6, 7: begin
        r = dd & ss;
        mc = (r != 0);
        mv = 0;
        wb = (op == 6);
      end
      8: begin r = dd & ~ss & mask; fwe = 0; end
      9: begin r = dd | ss; fwe = 0; end
      10: begin
        r = dd ^ ss;
        mc = (r != 0);
        mv = ((dd & sb) != 0) && ((ss & sb) != 0);
      end
      11: begin
        r = (dd >> 1) | (mc ? sb : 0);
        mc = dd & 1;
        mv = 0;
      end
      12: begin
        r = (dd >> 1) | (dd & sb);
        mc = dd & 1;
        mv = 0;
      end
      13: r = ((dd >> 8) & 255) | ((dd & 255) << 8);
      14: r = (dd & 128) ? ((dd | 16'hFF00) & 16'hFFFF) : (dd & 255);
      default: begin r = dd; fwe = 0; wb = 0; end
    endcase
    if (fwe) begin
      nsb = sb;
      mn = (r & nsb) != 0;
      mz = (r == 0);
    end
    e.r = r; e.wb = wb; e.fwe = fwe; e.op = op; e.byt = byt;
    expq.push_back(e);
  endtask

  // Per-clock comparison, sampled at the falling edge.
  task automatic step();
    int fw;
    bit fire_in, fire_out;
    exp_t e;
    fw = mc | (mz << 1) | (mn << 2) | (mv << 8);
    check(flags_word == fw[15:0], "R11/R13", "status word", flags_word, fw);
    check(br_taken == br_model(br_cond), "R12", "branch taken", br_taken, br_model(br_cond));
    check(in_ready == (!out_valid || out_ready), "R1", "in_ready", in_ready, !out_valid || out_ready);
    if (out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R1", "unexpected beat", out_result, 0);
      end else begin
        e = expq[0];
        check(out_result == e.r[15:0], tag_of(e.op, e.byt), "result", out_result, e.r);
        check(out_wb == e.wb, tag_of(e.op, e.byt), "writeback", out_wb, e.wb);
        check(out_flag_we == e.fwe, tag_of(e.op, e.byt), "flag write", out_flag_we, e.fwe);
      end
    end
    fire_out = out_valid && out_ready;
    fire_in  = in_valid && in_ready;
    if (fire_out && expq.size() != 0) void'(expq.pop_front());
    if (fire_in) model_exec(int'(in_op), in_byte, int'(in_src), int'(in_dst));
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (run && rst_n && !finished) step();
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = drain ? 1'b1 : (($urandom % 4) != 0);
      br_cond = 3'($urandom % 8);
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      finish_run();
    end
  end

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic send(int op, bit byt, int s, int d);
    bit acc;
    in_valid = 1'b1;
    in_op = 4'(op);
    in_byte = byt;
    in_src = 16'(s);
    in_dst = 16'(d);
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R14: reset state
    check(out_valid == 1'b0, "R14", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R14", "in_ready after reset", in_ready, 1);
    check(flags_word == 16'h0, "R14", "status after reset", flags_word, 0);
    @(posedge clk);
    #1 run = 1;

    send(0, 0, 16'h0001, 16'h7FFF);   // R2 signed overflow, N
    send(0, 1, 16'h0001, 16'h007F);   // R10 byte overflow
    send(0, 0, 16'h0001, 16'hFFFF);   // R2 carry out, zero
    send(1, 0, 16'h0001, 16'h0001);   // R2 carry in -> 3
    send(2, 0, 16'h0007, 16'h0005);   // R3 borrow
    send(3, 1, 16'h0001, 16'h0010);   // R3 subtract with C = 0
    send(4, 0, 16'h1234, 16'h1234);   // R3 compare equal, no writeback
    send(5, 1, 16'h0001, 16'h0099);   // R4 byte 99+1+C -> carry
    send(5, 0, 16'h0000, 16'h9999);   // R4 word boundary with carry
    send(5, 0, 16'h5678, 16'h1234);   // R4 ordinary sum
    send(6, 0, 16'h0F0F, 16'h00F0);   // R5 zero result
    send(7, 0, 16'h8001, 16'h8000);   // R5 test, no writeback
    send(10, 0, 16'h8001, 16'h8000);  // R6 both negative
    send(10, 1, 16'h0080, 16'h0080);  // R6 byte, zero result, V set
    send(8, 0, 16'h00FF, 16'h1234);   // R7 clear bits, flags kept
    send(9, 1, 16'h0001, 16'h0080);   // R7 set bits byte
    send(0, 0, 16'h0000, 16'h0001);   // force C = 0
    send(11, 0, 16'h0000, 16'h0003);  // R8 rotate, C in 0
    send(11, 1, 16'h0000, 16'h0002);  // R8 byte rotate, C in 1
    send(12, 1, 16'h0000, 16'h0081);  // R8 byte arithmetic shift
    send(13, 1, 16'h0000, 16'h12AB);  // R9 swap ignores byte bit
    send(14, 0, 16'h0000, 16'h0080);  // R9 sign extend negative
    send(14, 1, 16'h0000, 16'h017F);  // R9 sign extend positive
    send(15, 0, 16'h5555, 16'hAAAA);  // R7 reserved

    for (int i = 0; i < 800; i++) begin
      send(int'($urandom % 16), bit'($urandom % 2), int'($urandom % 65536), int'($urandom % 65536));
    end

    drain = 1;
    repeat (6) @(posedge clk);
    #1;
    check(expq.size() == 0, "R1", "beats outstanding after drain", expq.size(), 0);
    finish_run();
  end

endmodule